// File: doc/BRIEF.md
# UART Receive Character Queue with Idle Timeout

This block sits between a UART deserializer and the host register interface. Each character that the deserializer assembles is pushed into a 16-deep byte queue. The oldest stored character is always visible on the host read port, and a host read strobe removes it. The block raises a level interrupt when the number of stored characters reaches a trigger level that software selects. When FIFO mode is switched off, the queue behaves as a single holding register.

When characters sit in the queue below the trigger level, the host must still learn about them. An idle timer counts bit-time strobes. When it reaches four times the programmed data word length plus twelve, it flags a timeout. The timer restarts at the centre of every received stop bit and on every host read. It never runs while the queue is empty. The timeout output has its own enable input, so the host can mask it without losing the pending condition.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty: `data_ready`, `lvl_irq`, `tmo_irq` and `overrun` are 0, and `rd_data` is 0x00.
- R2: In FIFO mode (`fifo_en`=1), up to 16 characters are stored and read back in arrival order. `rd_data` always shows the oldest stored character, and a cycle with `rd_en`=1 removes it.
- R3: A write while 16 characters are stored and no read happens in the same cycle discards the new character and sets `overrun`. `overrun` clears on the next cycle with `rd_en`=1.
- R4: A read while the queue is empty leaves `rd_data` at the last character read and leaves the storage unchanged. A following write is the next character read.
- R5: `trig_sel` encodes the trigger level as 2'b00=1, 2'b01=4, 2'b10=8 and 2'b11=14 characters. `lvl_irq` is 1 exactly while the stored count is at least that level.
- R6: `data_ready` is 1 while at least one character is stored, including when the count exceeds the trigger level.
- R7: With the queue non-empty, the timeout becomes pending on the `bit_tick` strobe that completes 4×`word_len`+12 strobes since the last restart. It shows on `tmo_irq` after that clock edge.
- R8: A `stop_mid` strobe and a host read each restart the timeout count.
- R9: The timeout never becomes pending while the queue is empty, however many `bit_tick` strobes arrive.
- R10: `tmo_irq` is the pending timeout gated by `tmo_en`. The pending condition clears on a host read or on a newly written character.
- R11: With `fifo_en`=0 the block holds one character. The trigger level is 1 whatever `trig_sel` says, and a second write before a read is an overrun that keeps the first character.
- R12: Any change of `fifo_en` empties the queue and clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects 16-deep FIFO mode, 0 selects a single holding register |
| trig_sel | input | 2 | Trigger level select (00=1, 01=4, 10=8, 11=14) |
| word_len | input | 4 | Programmed data bits per character |
| tmo_en | input | 1 | Enables the timeout interrupt output |
| bit_tick | input | 1 | One-cycle strobe per serial bit time |
| stop_mid | input | 1 | One-cycle strobe at the centre of a received stop bit |
| wr_valid | input | 1 | Deserializer presents a new character |
| wr_data | input | 8 | Character from the deserializer |
| rd_en | input | 1 | Host read of the receive holding register |
| rd_data | output | 8 | Oldest stored character (last read one when empty) |
| data_ready | output | 1 | At least one character stored |
| lvl_irq | output | 1 | Stored count has reached the trigger level |
| tmo_irq | output | 1 | Enabled idle timeout pending |
| overrun | output | 1 | A character was dropped because the queue was full |

## Verification
The hardest state to reach is a timeout that becomes pending one strobe after a restart that was not caused by the write that filled the queue. Examples are a lone stop-bit strobe partway through the count, or a host read that leaves data behind. The bench builds each case from directed strobe counts. It runs exactly one strobe short of the limit, then the final strobe, so an off-by-one limit or a missed restart shows up. The full-queue overrun is reached by sixteen back-to-back writes followed by a seventeenth. The whole contents are then drained to show that the extra character never entered.

// File: rtl/uart_rx_queue_pkg.sv
`timescale 1ns/1ps
package uart_rx_queue_pkg;

    // Receive trigger level for each select code.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        case (sel)
            2'b00:   lvl = 5'd1;
            2'b01:   lvl = 5'd4;
            2'b10:   lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          overrun
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            last;
        logic                     ovr;
        logic                     en;
    } store_t;

    store_t q, d;
    logic [CW-1:0] cap;
    logic          full, empty, do_rd, do_wr, flush;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d     = q;
        cap   = fifo_en ? CW'(DEPTH) : CW'(1);
        full  = (q.cnt >= cap);
        empty = (q.cnt == '0);
        flush = (fifo_en != q.en);
        do_rd = rd_en && !empty && !flush;
        do_wr = wr_valid && (!full || do_rd) && !flush;
        d.en  = fifo_en;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
            d.ovr = 1'b0;
        end else begin
            if (do_rd) begin
                d.last = q.mem[q.rp];
                d.rp   = bump(q.rp);
            end
            if (do_wr) begin
                d.mem[q.wp] = wr_data;
                d.wp        = bump(q.wp);
            end
            d.cnt = q.cnt + CW'(do_wr) - CW'(do_rd);
            if (rd_en)
                d.ovr = 1'b0;
            if (wr_valid && !do_wr)
                d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = (q.cnt == '0) ? q.last : q.mem[q.rp];
    assign count   = q.cnt;
    assign overrun = q.ovr;

    // R2: occupancy never exceeds the storage depth
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R3: dropped character on a full queue raises overrun
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CW'(DEPTH) && wr_valid && !rd_en && fifo_en && q.en) |=> overrun);

    // R4: reading an empty queue keeps the presented value
    p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && rd_en && !wr_valid && fifo_en == q.en) |=> $stable(rd_data));

    // R11: single holding register mode never holds two characters
    p_single_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !q.en) |=> (count <= CW'(1)));

    // R12: toggling the mode empties the queue
    p_mode_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != q.en) |=> (count == '0 && !overrun));

endmodule

// File: rtl/rxq_timeout.sv
`timescale 1ns/1ps
module rxq_timeout #(
    parameter int LEN_W = 4,
    localparam int MAXL = (1 << LEN_W) - 1,
    localparam int TW   = $clog2(4 * MAXL + 13)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] word_len,
    input  logic             bit_tick,
    input  logic             stop_mid,
    input  logic             rd_en,
    input  logic             wr_valid,
    input  logic             nonempty,
    output logic             pending
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmo_t;

    tmo_t q, d;
    logic [TW-1:0] limit, nxt;

    always_comb begin
        d     = q;
        limit = TW'({word_len, 2'b00}) + TW'(12);
        nxt   = q.cnt + TW'(1);
        if (!nonempty) begin
            d.cnt  = '0;
            d.pend = 1'b0;
        end else if (stop_mid || rd_en) begin
            d.cnt = '0;
        end else if (bit_tick) begin
            if (nxt >= limit) begin
                d.cnt  = '0;
                d.pend = 1'b1;
            end else begin
                d.cnt = nxt;
            end
        end
        if (rd_en || wr_valid)
            d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;

    // R9: no pending timeout after an empty cycle
    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> !pending);

    // R7: timeout only becomes pending on a bit-time strobe
    p_tick_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(bit_tick));

    // R10: a read or a new character clears the pending timeout
    p_clear_on_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_valid) |=> !pending);

endmodule

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue
    import uart_rx_queue_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int LEN_W = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [LEN_W-1:0] word_len,
    input  logic             tmo_en,
    input  logic             bit_tick,
    input  logic             stop_mid,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    output logic             data_ready,
    output logic             lvl_irq,
    output logic             tmo_irq,
    output logic             overrun
);

    logic [CW-1:0] count;
    logic [CW-1:0] trig;
    logic          tmo_pend;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .count    (count),
        .overrun  (overrun)
    );

    rxq_timeout #(.LEN_W(LEN_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_len (word_len),
        .bit_tick (bit_tick),
        .stop_mid (stop_mid),
        .rd_en    (rd_en),
        .wr_valid (wr_valid),
        .nonempty (data_ready),
        .pending  (tmo_pend)
    );

    always_comb begin
        trig       = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
        data_ready = (count != '0);
        lvl_irq    = (count >= trig);
        tmo_irq    = tmo_en && tmo_pend;
    end

    // R6: the level interrupt implies data is present
    p_lvl_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_irq |-> data_ready);

endmodule

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'b11;
    logic [3:0] word_len = 4'd7;
    logic       tmo_en = 1'b1;
    logic       bit_tick = 1'b0;
    logic       stop_mid = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, lvl_irq, tmo_irq, overrun;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .word_len(word_len), .tmo_en(tmo_en), .bit_tick(bit_tick),
        .stop_mid(stop_mid), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .data_ready(data_ready),
        .lvl_irq(lvl_irq), .tmo_irq(tmo_irq), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        wr_valid = 1'b1; wr_data = b; stop_mid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; stop_mid = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic flush_fifo();
        fifo_en = 1'b0; @(negedge clk);
        fifo_en = 1'b1; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data_ready", data_ready, 0);
        chk("R1 lvl_irq", lvl_irq, 0);
        chk("R1 tmo_irq", tmo_irq, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        flush_fifo();
        trig_sel = 2'b11;
        for (int i = 0; i < 16; i++) push(8'(i * 17 + 3));
        chk("R6 ready above trigger", data_ready, 1);
        chk("R5 level at 16", lvl_irq, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order", rd_data, (i * 17 + 3) & 8'hFF);
            pop();
        end
        chk("R6 ready after drain", data_ready, 0);
    endtask

    task automatic t_overrun();
        flush_fifo();
        for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
        chk("R3 no overrun at 16", overrun, 0);
        push(8'hEE);
        chk("R3 overrun set", overrun, 1);
        chk("R3 head kept", rd_data, 8'h40);
        pop();
        chk("R3 overrun cleared by read", overrun, 0);
        for (int i = 1; i < 16; i++) begin
            chk("R3 contents", rd_data, 8'h40 + i);
            pop();
        end
        chk("R3 dropped char absent", data_ready, 0);
    endtask

    task automatic t_empty_read();
        flush_fifo();
        push(8'hA7);
        pop();
        chk("R4 last value shown", rd_data, 8'hA7);
        pop();
        chk("R4 read empty keeps value", rd_data, 8'hA7);
        chk("R4 still empty", data_ready, 0);
        push(8'h5A);
        chk("R4 next write is head", rd_data, 8'h5A);
        pop();
        chk("R4 empty after", data_ready, 0);
    endtask

    task automatic t_trigger();
        int lv[4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            flush_fifo();
            trig_sel = 2'(s);
            for (int i = 0; i < lv[s] - 1; i++) push(8'(i));
            chk("R5 below level", lvl_irq, 0);
            push(8'hFF);
            chk("R5 at level", lvl_irq, 1);
        end
        trig_sel = 2'b11;
    endtask

    task automatic t_timeout_len(input logic [3:0] len);
        int lim = 4 * len + 12;
        flush_fifo();
        word_len = len;
        push(8'h11);
        ticks(lim - 1);
        chk("R7 one short", tmo_irq, 0);
        ticks(1);
        chk("R7 at limit", tmo_irq, 1);
        pop();
        chk("R10 read clears", tmo_irq, 0);
    endtask

    task automatic t_reload();
        word_len = 4'd7;
        flush_fifo();
        push(8'h21); push(8'h22);
        ticks(30);
        stop_mid = 1'b1; @(negedge clk); stop_mid = 1'b0;
        ticks(39);
        chk("R8 stop_mid restart", tmo_irq, 0);
        ticks(1);
        chk("R8 after stop restart", tmo_irq, 1);
        push(8'h23);
        chk("R10 new char clears", tmo_irq, 0);
        ticks(20);
        pop();
        ticks(39);
        chk("R8 read restart", tmo_irq, 0);
        ticks(1);
        chk("R8 after read restart", tmo_irq, 1);
    endtask

    task automatic t_empty_quiet();
        flush_fifo();
        ticks(120);
        chk("R9 empty no timeout", tmo_irq, 0);
    endtask

    task automatic t_gate();
        word_len = 4'd7;
        flush_fifo();
        tmo_en = 1'b0;
        push(8'h31);
        ticks(40);
        chk("R10 masked", tmo_irq, 0);
        tmo_en = 1'b1;
        #1;
        chk("R10 unmasked pending", tmo_irq, 1);
        @(negedge clk);
    endtask

    task automatic t_single();
        fifo_en = 1'b0; @(negedge clk);
        trig_sel = 2'b11;
        push(8'hC1);
        chk("R11 ready", data_ready, 1);
        chk("R11 level one", lvl_irq, 1);
        push(8'hC2);
        chk("R11 overrun", overrun, 1);
        chk("R11 first kept", rd_data, 8'hC1);
        pop();
        chk("R11 empty after read", data_ready, 0);
        fifo_en = 1'b1; @(negedge clk);
    endtask

    task automatic t_flush();
        flush_fifo();
        push(8'h01); push(8'h02); push(8'h03);
        fifo_en = 1'b0; @(negedge clk);
        chk("R12 mode change empties", data_ready, 0);
        fifo_en = 1'b1; @(negedge clk);
        chk("R12 still empty", data_ready, 0);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_overrun();
        t_empty_read();
        t_trigger();
        t_timeout_len(4'd7);
        t_timeout_len(4'd5);
        t_timeout_len(4'd8);
        t_reload();
        t_empty_quiet();
        t_gate();
        t_single();
        t_flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule